// File: doc/BRIEF.md
# Thermal Fan Override and Critical Shutdown Monitor

This block watches a stream of paired temperature readings from two remote sensing channels. It decides when the fan must run at full speed regardless of its speed loop, and when the board must be told to shut down. Each reading is an 8-bit two's-complement value in whole degrees. It arrives together with a per-channel open-diode flag on a valid/ready sample interface. The block always accepts samples, so `smp_ready` is tied high and there is never back-pressure. A sample counts only in a cycle where `smp_valid` is high. All decisions are updated on accepted samples, and nothing else moves them.

The fan override has hysteresis. It turns on as soon as either channel exceeds its upper limit. It turns off only once both channels sit below their own release thresholds. A sensor fault also forces the fan on, for as long as that fault is reported: either an open diode or both channels reading exactly zero (both shorted). The shutdown output uses a separate critical limit per channel and a consecutive-sample filter whose length is set by a 4-bit code. Software programs all thresholds and the configuration byte through a simple write port.

Top module: `thermal_guard`

## Requirements
- R1: After reset, both outputs are low. The upper limits are +70 and the release thresholds are +60 on both channels. The critical limit is +108 on channel 0 and +88 on channel 1. The filter code is 2 and shutdown is enabled.
- R2: An accepted sample with either reading strictly greater than that channel's upper limit sets `fan_force_on` from the next cycle. A reading equal to the limit does not set it.
- R3: Once set by temperature, `fan_force_on` stays high until an accepted sample shows both readings strictly below their own release thresholds. One channel below its threshold, or a reading equal to it, keeps the fan on.
- R4: An accepted sample with either open-diode flag high forces `fan_force_on` high. The fault component clears on the next accepted sample without the flag.
- R5: An accepted sample where both readings are 0x00 forces `fan_force_on` high. A zero on only one channel does not.
- R6: A reading at or above its channel's critical limit counts as a fault for that channel. Each channel counts its own consecutive faults, and a reading below the limit resets that channel's count to zero. `th_shut` is high while either count has reached the filter code plus one.
- R7: Filter code 0 trips on the first faulty sample. Code 15 needs 16 consecutive faults, and the count saturates so that `th_shut` holds on further faults.
- R8: Configuration bit 4 is the shutdown enable. While it is 0, `th_shut` is low. Setting it again exposes a count that has already reached its target.
- R9: `smp_ready` is always high. Cycles without `smp_valid` change neither output, whatever the readings and flags carry.
- R10: Write addresses are 0 upper0, 1 release0, 2 critical0, 3 upper1, 4 release1, 5 critical1 and 6 configuration (bits 3:0 filter code, bit 4 enable). A write to address 7 changes nothing.
- R11: All comparisons are signed, so negative thresholds and readings order correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, always high |
| smp_t0 | input | 8 | Channel 0 reading, two's complement |
| smp_t1 | input | 8 | Channel 1 reading, two's complement |
| smp_open0 | input | 1 | Channel 0 open-diode flag |
| smp_open1 | input | 1 | Channel 1 open-diode flag |
| fan_force_on | output | 1 | Fan full-on override |
| th_shut | output | 1 | Thermal shutdown request |

## Verification
On every cycle the assertions check the immediate sample-to-output relations. A hot reading, an open diode or a double zero turns the fan on in the next cycle. Both channels below critical clear the shutdown. A disabled enable keeps shutdown low, idle cycles leave both outputs frozen, and ready never drops. The hysteresis release, the reset values, the exact count of consecutive faults for each filter code, counter saturation and the effect of ignored addresses depend on sample history. Only the directed bench scenarios can show these.

// File: rtl/thg_pkg.sv
package thg_pkg;
  localparam int TEMP_W  = 8;
  localparam int QUEUE_W = 4;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int EN_BIT  = 4;

  localparam logic [ADDR_W-1:0] A_UPPER0   = 3'd0;
  localparam logic [ADDR_W-1:0] A_RELEASE0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CRIT0    = 3'd2;
  localparam logic [ADDR_W-1:0] A_UPPER1   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RELEASE1 = 3'd4;
  localparam logic [ADDR_W-1:0] A_CRIT1    = 3'd5;
  localparam logic [ADDR_W-1:0] A_CONFIG   = 3'd6;

  localparam logic [TEMP_W-1:0]  RST_UPPER   = 8'd70;
  localparam logic [TEMP_W-1:0]  RST_RELEASE = 8'd60;
  localparam logic [TEMP_W-1:0]  RST_CRIT0   = 8'd108;
  localparam logic [TEMP_W-1:0]  RST_CRIT1   = 8'd88;
  localparam logic [QUEUE_W-1:0] RST_QUEUE   = 4'd2;
endpackage

// File: rtl/thg_regfile.sv
module thg_regfile
  import thg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [1:0][TEMP_W-1:0]   upper,
  output logic [1:0][TEMP_W-1:0]   rel,
  output logic [1:0][TEMP_W-1:0]   crit,
  output logic [QUEUE_W-1:0]       queue,
  output logic                     shut_en
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{wr_data[DATA_W-1:EN_BIT+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper   <= {RST_UPPER, RST_UPPER};
      rel     <= {RST_RELEASE, RST_RELEASE};
      crit    <= {RST_CRIT1, RST_CRIT0};
      queue   <= RST_QUEUE;
      shut_en <= 1'b1;
    end else if (wr_en) begin
      case (wr_addr)
        A_UPPER0:   upper[0] <= wr_data[TEMP_W-1:0];
        A_RELEASE0: rel[0]   <= wr_data[TEMP_W-1:0];
        A_CRIT0:    crit[0]  <= wr_data[TEMP_W-1:0];
        A_UPPER1:   upper[1] <= wr_data[TEMP_W-1:0];
        A_RELEASE1: rel[1]   <= wr_data[TEMP_W-1:0];
        A_CRIT1:    crit[1]  <= wr_data[TEMP_W-1:0];
        A_CONFIG: begin
          queue   <= wr_data[QUEUE_W-1:0];
          shut_en <= wr_data[EN_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/thg_fan_hyst.sv
module thg_fan_hyst
  import thg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc,
  input  logic [1:0][TEMP_W-1:0] temp,
  input  logic [1:0]             open_flag,
  input  logic [1:0][TEMP_W-1:0] upper,
  input  logic [1:0][TEMP_W-1:0] rel,
  output logic                   force_on
);
  logic [1:0] over, below;
  logic       hot_q, diag_q, both_zero;

  for (genvar c = 0; c < 2; c++) begin : g_cmp
    assign over[c]  = $signed(temp[c]) > $signed(upper[c]);
    assign below[c] = $signed(temp[c]) < $signed(rel[c]);
  end

  assign both_zero = (temp[0] == '0) && (temp[1] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hot_q  <= 1'b0;
      diag_q <= 1'b0;
    end else if (acc) begin
      hot_q  <= (|over) | (hot_q & ~(&below));
      diag_q <= (|open_flag) | both_zero;
    end
  end

  assign force_on = hot_q | diag_q;
endmodule

// File: rtl/thg_crit_counter.sv
module thg_crit_counter
  import thg_pkg::*;
#(
  parameter int QW = QUEUE_W,
  localparam int CW = QW + 1,
  localparam int MAXC = 1 << QW
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] crit,
  input  logic [QW-1:0]     code,
  output logic              trip
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need;
  logic          fault;

  assign fault = $signed(temp) >= $signed(crit);
  assign need  = {1'b0, code} + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (acc) begin
      if (!fault)                  cnt_q <= '0;
      else if (cnt_q != CW'(MAXC)) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign trip = cnt_q >= need;
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [TEMP_W-1:0] smp_t0,
  input  logic [TEMP_W-1:0] smp_t1,
  input  logic              smp_open0,
  input  logic              smp_open1,
  output logic              fan_force_on,
  output logic              th_shut
);
  logic [1:0][TEMP_W-1:0] upper_q, rel_q, crit_q, temp;
  logic [QUEUE_W-1:0]     queue_q;
  logic                   shut_en;
  logic                   acc;
  logic [1:0]             trip;

  assign smp_ready = 1'b1;
  assign acc       = smp_valid & smp_ready;
  assign temp      = {smp_t1, smp_t0};

  thg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upper(upper_q), .rel(rel_q), .crit(crit_q), .queue(queue_q), .shut_en(shut_en)
  );

  thg_fan_hyst u_fan (
    .clk(clk), .rst_n(rst_n), .acc(acc), .temp(temp),
    .open_flag({smp_open1, smp_open0}), .upper(upper_q), .rel(rel_q),
    .force_on(fan_force_on)
  );

  for (genvar c = 0; c < 2; c++) begin : g_ch
    thg_crit_counter #(.QW(QUEUE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .acc(acc), .temp(temp[c]), .crit(crit_q[c]),
      .code(queue_q), .trip(trip[c])
    );
  end

  assign th_shut = shut_en & (|trip);
endmodule

// File: rtl/thg_checker.sv
module thg_checker
  import thg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [TEMP_W-1:0] smp_t0,
  input logic [TEMP_W-1:0] smp_t1,
  input logic              smp_open0,
  input logic              smp_open1,
  input logic              fan_force_on,
  input logic              th_shut,
  input logic              shut_en,
  input logic [TEMP_W-1:0] upper0,
  input logic [TEMP_W-1:0] upper1,
  input logic [TEMP_W-1:0] crit0,
  input logic [TEMP_W-1:0] crit1
);
  AST_HOT_FORCES_FAN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && ($signed(smp_t0) > $signed(upper0) || $signed(smp_t1) > $signed(upper1))
    |=> fan_force_on); // R2
  AST_OPEN_FORCES_FAN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (smp_open0 || smp_open1) |=> fan_force_on); // R4
  AST_SHORT_FORCES_FAN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_t0 == '0 && smp_t1 == '0 |=> fan_force_on); // R5
  AST_COOL_CLEARS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && $signed(smp_t0) < $signed(crit0) && $signed(smp_t1) < $signed(crit1)
    |=> !th_shut); // R6
  AST_DISABLED_NO_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_en |-> !th_shut); // R8
  AST_IDLE_FAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(fan_force_on)); // R9
  AST_IDLE_SHUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid && !wr_en |=> $stable(th_shut)); // R9
  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready); // R9
endmodule

bind thermal_guard thg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_t0(smp_t0), .smp_t1(smp_t1), .smp_open0(smp_open0), .smp_open1(smp_open1),
  .fan_force_on(fan_force_on), .th_shut(th_shut), .shut_en(shut_en),
  .upper0(upper_q[0]), .upper1(upper_q[1]), .crit0(crit_q[0]), .crit1(crit_q[1])
);

// File: tb/tb_thermal_guard.sv
module tb_thermal_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [7:0] smp_t0 = '0, smp_t1 = '0;
  logic       smp_open0 = 1'b0, smp_open1 = 1'b0;
  logic       fan_force_on, th_shut;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  thermal_guard dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_t0(smp_t0), .smp_t1(smp_t1),
    .smp_open0(smp_open0), .smp_open1(smp_open1),
    .fan_force_on(fan_force_on), .th_shut(th_shut)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    smp_valid = 1'b0; wr_en = 1'b0; smp_open0 = 1'b0; smp_open1 = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic smp(input logic [7:0] a, input logic [7:0] b, input logic o0, input logic o1);
    @(negedge clk); smp_valid = 1'b1; smp_t0 = a; smp_t1 = b; smp_open0 = o0; smp_open1 = o1;
    @(negedge clk); smp_valid = 1'b0; smp_open0 = 1'b0; smp_open1 = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 fan low after reset", fan_force_on, 1'b0);
    chk("R1 shut low after reset", th_shut, 1'b0);
    chk("R9 ready high", smp_ready, 1'b1);
    smp(8'd70, 8'd70, 0, 0); chk("R2 equal to upper keeps fan off", fan_force_on, 1'b0);
    smp(8'd20, 8'd71, 0, 0); chk("R2 above upper1 sets fan", fan_force_on, 1'b1);
    do_reset();
    smp(8'd107, 8'd87, 0, 0); smp(8'd107, 8'd87, 0, 0); smp(8'd107, 8'd87, 0, 0);
    chk("R1 below default critical no shut", th_shut, 1'b0);
    smp(8'd108, 8'd20, 0, 0); smp(8'd108, 8'd20, 0, 0);
    chk("R1 two faults with code 2 not enough", th_shut, 1'b0);
    smp(8'd108, 8'd20, 0, 0); chk("R1 third fault ch0 trips", th_shut, 1'b1);
    do_reset();
    smp(8'd20, 8'd88, 0, 0); smp(8'd20, 8'd88, 0, 0); smp(8'd20, 8'd88, 0, 0);
    chk("R1 ch1 critical 88 trips", th_shut, 1'b1);
  endtask

  task automatic t_hysteresis();
    do_reset();
    smp(8'd71, 8'd50, 0, 0); chk("R3 set", fan_force_on, 1'b1);
    smp(8'd65, 8'd50, 0, 0); chk("R3 between limits holds", fan_force_on, 1'b1);
    smp(8'd59, 8'd60, 0, 0); chk("R3 equal release holds", fan_force_on, 1'b1);
    smp(8'd59, 8'd59, 0, 0); chk("R3 both below releases", fan_force_on, 1'b0);
  endtask

  task automatic t_open_short();
    do_reset();
    smp(8'd20, 8'd20, 1, 0); chk("R4 open0 forces fan", fan_force_on, 1'b1);
    smp(8'd20, 8'd20, 0, 0); chk("R4 clears without flag", fan_force_on, 1'b0);
    smp(8'd20, 8'd20, 0, 1); chk("R4 open1 forces fan", fan_force_on, 1'b1);
    smp(8'd0, 8'd0, 0, 0);   chk("R5 both zero forces fan", fan_force_on, 1'b1);
    smp(8'd0, 8'd5, 0, 0);   chk("R5 single zero no fan", fan_force_on, 1'b0);
  endtask

  task automatic t_signed();
    do_reset();
    wr(3'd0, 8'hF6); wr(3'd1, 8'hEC);
    smp(8'hFB, 8'd10, 0, 0); chk("R11 -5 above -10 sets fan", fan_force_on, 1'b1);
    smp(8'hE7, 8'd10, 0, 0); chk("R11 -25 below -20 releases", fan_force_on, 1'b0);
    smp(8'h80, 8'h80, 0, 0); chk("R11 -128 no shut", th_shut, 1'b0);
  endtask

  task automatic t_consecutive();
    do_reset();
    smp(8'd108, 8'd108, 0, 0); smp(8'd108, 8'd108, 0, 0); smp(8'd50, 8'd50, 0, 0);
    smp(8'd108, 8'd108, 0, 0); smp(8'd108, 8'd108, 0, 0);
    chk("R6 broken run restarts count", th_shut, 1'b0);
    smp(8'd108, 8'd108, 0, 0); chk("R6 consecutive run trips", th_shut, 1'b1);
    smp(8'd120, 8'd20, 0, 0); chk("R6 stays while at or above", th_shut, 1'b1);
    smp(8'd107, 8'd20, 0, 0); chk("R6 drops below critical", th_shut, 1'b0);
  endtask

  task automatic t_queue();
    do_reset();
    wr(3'd6, 8'h10);
    smp(8'd108, 8'd0, 0, 0); chk("R7 code 0 trips on first", th_shut, 1'b1);
    smp(8'd100, 8'd0, 0, 0); chk("R7 clears", th_shut, 1'b0);
    wr(3'd6, 8'h1F);
    for (int i = 0; i < 15; i++) smp(8'd110, 8'd0, 0, 0);
    chk("R7 code 15 not tripped after 15", th_shut, 1'b0);
    smp(8'd110, 8'd0, 0, 0); chk("R7 code 15 trips at 16", th_shut, 1'b1);
    smp(8'd110, 8'd0, 0, 0); chk("R7 saturated holds", th_shut, 1'b1);
  endtask

  task automatic t_enable();
    do_reset();
    wr(3'd6, 8'h02);
    for (int i = 0; i < 4; i++) smp(8'd120, 8'd20, 0, 0);
    chk("R8 disabled holds low", th_shut, 1'b0);
    wr(3'd6, 8'h12); chk("R8 re-enable exposes count", th_shut, 1'b1);
  endtask

  task automatic t_idle_and_addr();
    do_reset();
    smp(8'd80, 8'd20, 0, 0); chk("R9 setup fan on", fan_force_on, 1'b1);
    @(negedge clk); smp_t0 = 8'd0; smp_t1 = 8'd0; smp_open0 = 1'b1;
    repeat (5) @(negedge clk);
    smp_open0 = 1'b0;
    chk("R9 idle cycles keep fan", fan_force_on, 1'b1);
    do_reset();
    wr(3'd7, 8'h00);
    smp(8'd65, 8'd20, 0, 0); chk("R10 address 7 ignored", fan_force_on, 1'b0);
    wr(3'd3, 8'd30);
    smp(8'd20, 8'd31, 0, 0); chk("R10 address 3 is upper1", fan_force_on, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_hysteresis();
    t_open_short();
    t_signed();
    t_consecutive();
    t_queue();
    t_enable();
    t_idle_and_addr();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule